// File: doc/BRIEF.md
# Per-Channel TDC Timing Histogrammer

This block gathers monitoring statistics from a bank of time-to-digital converter channels. On every bunch-crossing strobe it is given one hit flag and one fine-time code per channel. For each channel that reports a hit, the histogram bin selected by that channel's time code is incremented. For each channel without a hit, that channel's empty-crossing counter is incremented. A single global counter records how many crossings have been logged. When that count reaches its ceiling of 2^LOG_W, the block freezes every counter until it is cleared, so all statistics cover the same window.

A controller behind a serial configuration link reads the counters through a simple registered read port. The address selects a channel and then a bin, that channel's empty count, or the global count. An enable input starts and pauses accumulation. A clear input zeroes everything.

The controller is a three-state machine. In `ST_IDLE` it waits and ignores strobes. In `ST_RUN` it accepts strobes. In `ST_FULL` the limit has been reached and every counter is frozen. The transitions are:
- `IDLE_TO_RUN` when enable is high.
- `RUN_TO_IDLE` when enable drops.
- `RUN_TO_FULL` when an accepted strobe brings the logged count to the limit.
- `ANY_TO_IDLE` on clear, which takes priority over everything else.

Top module: `tdc_histo`

## Requirements
- R1: After reset every bin counter, every empty counter and the global count read as zero, and `acq_running`, `acq_full` and `rd_valid` are low.
- R2: A strobe accepted while running increments, for each channel whose `hit_vld` bit is 1, the bin whose index equals that channel's time code `hit_time[c*TIME_W +: TIME_W]`. No other bin of that channel changes.
- R3: For each channel whose `hit_vld` bit is 0, an accepted strobe increments that channel's empty-crossing counter. A channel with a hit leaves its empty counter unchanged.
- R4: Each accepted strobe increments the global logged count by exactly one.
- R5: A bin counter that holds 2^BIN_W-1 keeps that value on further hits instead of wrapping.
- R6: When the global count reaches 2^LOG_W, the block enters the full state. In that state `acq_full` is 1, `acq_running` is 0, and no counter changes until a clear, whatever the strobes.
- R7: A strobe is accepted only when the block is already running and `acq_en` is 1 in the same cycle. Running starts on the first clock edge at which `acq_en` is high. Strobes outside these conditions change no counter.
- R8: `acq_clr` zeroes all counters at the next edge and returns the block to idle. It overrides a simultaneous strobe and the full state.
- R9: A read is issued with `rd_en` and `rd_addr = {channel, select}`. Select values 0..2^TIME_W-1 address bins, 2^TIME_W addresses the empty count, and 2^TIME_W+1 addresses the global count, for which the channel field is ignored. `rd_data` and `rd_valid`=1 appear one cycle after the request. `rd_valid` is 0 in any cycle that follows a cycle without a request.
- R10: A read issued in the same cycle as an accepted strobe returns the value from before that strobe's update. A later read returns the updated value.
- R11: Select codes above 2^TIME_W+1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Allows accumulation |
| acq_clr | input | 1 | Zeroes all counters, returns to idle |
| bx_stb | input | 1 | One pulse per bunch crossing |
| hit_vld | input | NUM_CH | Per-channel hit flag |
| hit_time | input | NUM_CH*TIME_W | Per-channel fine-time codes, channel c at bits c*TIME_W |
| rd_en | input | 1 | Read request |
| rd_addr | input | CH_AW+TIME_W+1 | {channel, select} |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | LOG_W+1 | Counter value, zero-extended |
| acq_running | output | 1 | Controller is in the running state |
| acq_full | output | 1 | Logged-crossing limit reached |

## Verification
The bench keeps 16 channels with 4-bit time codes, so every bin index and the full address map are exercised. It shrinks the bin counters to 4 bits and the global limit to 2^6 = 64 crossings. With those values, bin saturation is reached after fifteen hits and the full state after a few dozen strobes. Freezing, a read that collides with an update, and a clear that overrides a strobe are each observed through the read port.

// File: rtl/tdch_pkg.sv
package tdch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } acq_state_e;

endpackage

// File: rtl/tdch_ctrl.sv
module tdch_ctrl
    import tdch_pkg::*;
#(
    parameter int LOG_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acq_en,
    input  logic           acq_clr,
    input  logic           bx_stb,
    output logic           accept,
    output logic           running,
    output logic           full,
    output logic [LOG_W:0] log_cnt
);
    localparam logic [LOG_W:0] LOG_LIMIT = {1'b1, {LOG_W{1'b0}}};
    localparam logic [LOG_W:0] LOG_LAST  = LOG_LIMIT - 1'b1;

    acq_state_e state_q, state_d;
    logic [LOG_W:0] log_q;

    // Accepted strobe: running, still enabled, and no clear pending.
    assign accept = (state_q == ST_RUN) && acq_en && bx_stb && !acq_clr;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (acq_clr) begin
            state_d = ST_IDLE;                          // ANY_TO_IDLE
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acq_en) state_d = ST_RUN;       // IDLE_TO_RUN
                end
                ST_RUN: begin
                    if (accept && (log_q == LOG_LAST))
                        state_d = ST_FULL;              // RUN_TO_FULL
                    else if (!acq_en)
                        state_d = ST_IDLE;              // RUN_TO_IDLE
                end
                ST_FULL: state_d = ST_FULL;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Global logged-crossing counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       log_q <= '0;
        else if (acq_clr) log_q <= '0;
        else if (accept)  log_q <= log_q + 1'b1;
    end

    // Outputs decoded from state.
    always_comb begin
        running = 1'b0;
        full    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  running = 1'b1;
            ST_FULL: full    = 1'b1;
            default: ;
        endcase
    end

    assign log_cnt = log_q;

endmodule

// File: rtl/tdch_chan.sv
module tdch_chan #(
    parameter int TIME_W = 4,
    parameter int BIN_W  = 16,
    parameter int DATA_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              accept,
    input  logic              hit,
    input  logic [TIME_W-1:0] tcode,
    input  logic [TIME_W:0]   sel,
    output logic [DATA_W-1:0] word
);
    localparam int NBINS = 1 << TIME_W;
    localparam logic [BIN_W-1:0] BIN_MAX = {BIN_W{1'b1}};

    logic [BIN_W-1:0]  bin_q [NBINS];
    logic [DATA_W-1:0] empty_q;

    // One saturating counter per time code.
    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        logic bump;
        assign bump = accept && hit && (tcode == TIME_W'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bin_q[b] <= '0;
            else if (clr)
                bin_q[b] <= '0;
            else if (bump && (bin_q[b] != BIN_MAX))
                bin_q[b] <= bin_q[b] + 1'b1;
        end
    end

    // Empty-crossing counter; it never exceeds the global count, so it needs no saturation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             empty_q <= '0;
        else if (clr)           empty_q <= '0;
        else if (accept && !hit) empty_q <= empty_q + 1'b1;
    end

    // Local read selection.
    always_comb begin
        word = '0;
        if (!sel[TIME_W])
            word = DATA_W'(bin_q[sel[TIME_W-1:0]]);
        else if (sel == (TIME_W+1)'(NBINS))
            word = empty_q;
    end

endmodule

// File: rtl/tdch_rdmux.sv
module tdch_rdmux #(
    parameter int NUM_CH = 16,
    parameter int TIME_W = 4,
    parameter int DATA_W = 33,
    parameter int CH_AW  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [CH_AW-1:0]              ch,
    input  logic [TIME_W:0]               sel,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_word,
    input  logic [DATA_W-1:0]             log_cnt,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data
);
    localparam logic [TIME_W:0] SEL_GLOBAL = (TIME_W+1)'((1 << TIME_W) + 1);

    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        if (sel == SEL_GLOBAL)
            pick = log_cnt;
        else if (32'(ch) < NUM_CH)
            pick = ch_word[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= pick;
        end
    end

endmodule

// File: rtl/tdc_histo.sv
module tdc_histo #(
    parameter int NUM_CH = 16,
    parameter int TIME_W = 4,
    parameter int BIN_W  = 16,
    parameter int LOG_W  = 32,
    parameter int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int DATA_W = LOG_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acq_en,
    input  logic                     acq_clr,
    input  logic                     bx_stb,
    input  logic [NUM_CH-1:0]        hit_vld,
    input  logic [NUM_CH*TIME_W-1:0] hit_time,
    input  logic                     rd_en,
    input  logic [CH_AW+TIME_W:0]    rd_addr,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     acq_running,
    output logic                     acq_full
);
    logic                          accept;
    logic [LOG_W:0]                log_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_word;
    logic [TIME_W:0]               rd_sel;
    logic [CH_AW-1:0]              rd_ch;

    assign rd_sel = rd_addr[TIME_W:0];
    assign rd_ch  = rd_addr[CH_AW+TIME_W:TIME_W+1];

    tdch_ctrl #(.LOG_W(LOG_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq_en  (acq_en),
        .acq_clr (acq_clr),
        .bx_stb  (bx_stb),
        .accept  (accept),
        .running (acq_running),
        .full    (acq_full),
        .log_cnt (log_cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tdch_chan #(.TIME_W(TIME_W), .BIN_W(BIN_W), .DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (acq_clr),
            .accept (accept),
            .hit    (hit_vld[c]),
            .tcode  (hit_time[c*TIME_W +: TIME_W]),
            .sel    (rd_sel),
            .word   (ch_word[c])
        );
    end

    tdch_rdmux #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .DATA_W(DATA_W), .CH_AW(CH_AW)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .ch       (rd_ch),
        .sel      (rd_sel),
        .ch_word  (ch_word),
        .log_cnt  (DATA_W'(log_cnt)),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/tdc_histo_chk.sv
module tdc_histo_chk #(
    parameter int LOG_W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acq_en,
    input logic           acq_clr,
    input logic           bx_stb,
    input logic           rd_en,
    input logic           rd_valid,
    input logic           acq_running,
    input logic           acq_full,
    input logic [LOG_W:0] log_cnt
);
    localparam logic [LOG_W:0] LIMIT = {1'b1, {LOG_W{1'b0}}};

    AST_CLR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acq_clr |=> (!acq_full && !acq_running && log_cnt == '0)); // R8

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_full && !acq_clr) |=> acq_full); // R6

    AST_FULL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        acq_full |-> (log_cnt == LIMIT && !acq_running)); // R6

    AST_LOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        log_cnt <= LIMIT); // R6

    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_clr && !(acq_running && acq_en && bx_stb)) |=> $stable(log_cnt)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_clr && acq_running && acq_en && bx_stb) |=> (log_cnt == $past(log_cnt) + 1'b1)); // R4

    AST_RD_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R9

    AST_RD_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R9

endmodule

bind tdc_histo tdc_histo_chk #(.LOG_W(LOG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_en      (acq_en),
    .acq_clr     (acq_clr),
    .bx_stb      (bx_stb),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .acq_running (acq_running),
    .acq_full    (acq_full),
    .log_cnt     (log_cnt)
);

// File: tb/tb_tdc_histo.sv
module tb_tdc_histo;
    localparam int NUM_CH = 16;
    localparam int TIME_W = 4;
    localparam int BIN_W  = 4;
    localparam int LOG_W  = 6;
    localparam int CH_AW  = 4;
    localparam int DATA_W = LOG_W + 1;
    localparam int NBINS  = 1 << TIME_W;
    localparam int LIMIT  = 1 << LOG_W;
    localparam int BMAX   = (1 << BIN_W) - 1;
    localparam int SEL_EMPTY = NBINS;
    localparam int SEL_GLOB  = NBINS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_en = 1'b0, acq_clr = 1'b0, bx_stb = 1'b0, rd_en = 1'b0;
    logic [NUM_CH-1:0] hit_vld = '0;
    logic [NUM_CH*TIME_W-1:0] hit_time = '0;
    logic [CH_AW+TIME_W:0] rd_addr = '0;
    logic rd_valid, acq_running, acq_full;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int exp_bin [NUM_CH][NBINS];
    int exp_empty [NUM_CH];
    int exp_log = 0;

    always #2.5 clk = ~clk;

    tdc_histo #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .BIN_W(BIN_W), .LOG_W(LOG_W)) dut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .acq_clr(acq_clr), .bx_stb(bx_stb),
        .hit_vld(hit_vld), .hit_time(hit_time), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .acq_running(acq_running), .acq_full(acq_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int c = 0; c < NUM_CH; c++) begin
            exp_empty[c] = 0;
            for (int b = 0; b < NBINS; b++) exp_bin[c][b] = 0;
        end
        exp_log = 0;
    endtask

    // Reference update from the requirements (R2, R3, R4, R5, R6).
    task automatic model_stb(input logic [NUM_CH-1:0] v, input logic [NUM_CH*TIME_W-1:0] t);
        if (exp_log >= LIMIT) return;
        for (int c = 0; c < NUM_CH; c++) begin
            if (v[c]) begin
                int b = int'(t[c*TIME_W +: TIME_W]);
                if (exp_bin[c][b] < BMAX) exp_bin[c][b]++;
            end else exp_empty[c]++;
        end
        exp_log++;
    endtask

    task automatic rd(input int ch, input int sel, output int d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = {CH_AW'(ch), (TIME_W+1)'(sel)};
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 rd_valid", int'(rd_valid), 1);
        d = int'(rd_data);
    endtask

    task automatic rd_chk(input string req, input int ch, input int sel, input int exp);
        int d;
        rd(ch, sel, d);
        chk(req, d, exp);
    endtask

    task automatic strobe(input logic [NUM_CH-1:0] v, input logic [NUM_CH*TIME_W-1:0] t,
                          input bit accepted);
        @(negedge clk);
        bx_stb = 1'b1; hit_vld = v; hit_time = t;
        @(negedge clk);
        bx_stb = 1'b0; hit_vld = '0;
        if (accepted) model_stb(v, t);
    endtask

    task automatic enable_run();
        @(negedge clk);
        acq_en = 1'b1;
        @(negedge clk);
        chk("R7 running after enable", int'(acq_running), 1);
    endtask

    function automatic logic [NUM_CH*TIME_W-1:0] tcodes(input int c0, input int t0,
                                                      input int c1, input int t1);
        logic [NUM_CH*TIME_W-1:0] r = '0;
        r[c0*TIME_W +: TIME_W] = TIME_W'(t0);
        r[c1*TIME_W +: TIME_W] = TIME_W'(t1);
        return r;
    endfunction

    task automatic t_reset();
        chk("R1 running", int'(acq_running), 0);
        chk("R1 full", int'(acq_full), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        rd_chk("R1 bin", 5, 9, 0);
        rd_chk("R1 empty", 15, SEL_EMPTY, 0);
        rd_chk("R1 global", 0, SEL_GLOB, 0);
    endtask

    task automatic t_basic();
        logic [NUM_CH-1:0] v = '0;
        enable_run();
        v[0] = 1'b1; v[3] = 1'b1;
        strobe(v, tcodes(0, 5, 3, 15), 1'b1);
        rd_chk("R2 ch0 bin5", 0, 5, exp_bin[0][5]);
        rd_chk("R2 ch3 bin15", 3, 15, exp_bin[3][15]);
        rd_chk("R2 ch0 bin4 untouched", 0, 4, 0);
        rd_chk("R3 ch1 empty", 1, SEL_EMPTY, exp_empty[1]);
        rd_chk("R3 ch0 empty untouched", 0, SEL_EMPTY, 0);
        rd_chk("R4 global", 7, SEL_GLOB, exp_log);
        v = '0; v[3] = 1'b1;
        strobe(v, tcodes(3, 0, 3, 0), 1'b1);
        rd_chk("R2 ch3 bin0", 3, 0, exp_bin[3][0]);
        rd_chk("R3 ch0 empty", 0, SEL_EMPTY, exp_empty[0]);
        rd_chk("R4 global two", 2, SEL_GLOB, exp_log);
    endtask

    task automatic t_unused();
        rd_chk("R11 select 18", 3, NBINS + 2, 0);
        rd_chk("R11 select 31", 0, 31, 0);
    endtask

    task automatic t_disable();
        @(negedge clk);
        acq_en = 1'b0;
        bx_stb = 1'b1; hit_vld = '0;
        @(negedge clk);
        bx_stb = 1'b0;
        chk("R7 running after disable", int'(acq_running), 0);
        strobe('1, '0, 1'b0);
        rd_chk("R7 global frozen", 0, SEL_GLOB, exp_log);
        rd_chk("R7 empty frozen", 1, SEL_EMPTY, exp_empty[1]);
        rd_chk("R7 bin frozen", 4, 0, 0);
    endtask

    task automatic t_saturate();
        logic [NUM_CH-1:0] v = '0;
        v[2] = 1'b1;
        enable_run();
        for (int i = 0; i < BMAX + 5; i++) strobe(v, tcodes(2, 7, 2, 7), 1'b1);
        rd_chk("R5 bin saturates", 2, 7, BMAX);
        rd_chk("R5 model agrees", 2, 7, exp_bin[2][7]);
        rd_chk("R4 global after run", 0, SEL_GLOB, exp_log);
    endtask

    task automatic t_collide();
        int old_e = exp_empty[2];
        @(negedge clk);
        bx_stb = 1'b1; hit_vld = '0; hit_time = '0;
        rd_en = 1'b1; rd_addr = {CH_AW'(2), (TIME_W+1)'(SEL_EMPTY)};
        @(negedge clk);
        bx_stb = 1'b0; rd_en = 1'b0;
        model_stb('0, '0);
        chk("R10 read returns pre-update", int'(rd_data), old_e);
        rd_chk("R10 next read updated", 2, SEL_EMPTY, old_e + 1);
    endtask

    task automatic t_full();
        logic [NUM_CH-1:0] v = '0;
        v[9] = 1'b1;
        while (exp_log < LIMIT) strobe(v, tcodes(9, 3, 9, 3), 1'b1);
        chk("R6 full flag", int'(acq_full), 1);
        chk("R6 not running", int'(acq_running), 0);
        strobe('0, '0, 1'b0);
        strobe('0, '0, 1'b0);
        rd_chk("R6 global at limit", 0, SEL_GLOB, LIMIT);
        rd_chk("R6 empty frozen", 1, SEL_EMPTY, exp_empty[1]);
        rd_chk("R6 bin frozen", 9, 3, exp_bin[9][3]);
        chk("R6 still full", int'(acq_full), 1);
    endtask

    task automatic t_clear();
        @(negedge clk);
        acq_clr = 1'b1; bx_stb = 1'b1; hit_vld = '1; hit_time = '0;
        @(negedge clk);
        acq_clr = 1'b0; bx_stb = 1'b0; hit_vld = '0;
        model_zero();
        chk("R8 full cleared", int'(acq_full), 0);
        chk("R8 idle after clear", int'(acq_running), 0);
        rd_chk("R8 global zero", 0, SEL_GLOB, 0);
        rd_chk("R8 bin zero", 9, 3, 0);
        rd_chk("R8 bin0 zero despite strobe", 4, 0, 0);
        rd_chk("R8 empty zero", 1, SEL_EMPTY, 0);
    endtask

    initial begin
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_unused();
        t_disable();
        t_saturate();
        t_collide();
        t_full();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule